// File: doc/BRIEF.md
# Bidirectional serial-in latched output driver

This block is a 32-stage serial-in, parallel-out register meant to drive a row of output lines. It loads serial data into a shift chain on every falling edge of a serial clock. A direction input picks which of two serial ports feeds the chain and which port carries the far end of the chain out. The serial output of one instance can feed the serial input of a second instance, so several instances form one long chain.

The parallel outputs do not take values from the chain directly. A level-sensitive latch stands between the chain and the outputs. While the latch enable is high, the outputs follow the chain as it shifts. While the enable is low, the outputs keep the last value they had. A blank input forces every parallel output low without changing the latch contents. Each serial port has its own input, output and output-enable signal, so the user can build a shared pin outside the block.

Top module: `serial_latched_driver`

## Requirements
- R1: With `dir_i` high (forward), each falling edge of `sclk_i` loads `pa_i` into stage 1 and moves stage k to stage k+1. `pb_o` shows stage 32. Stage k appears on `par_o[k-1]`.
- R2: With `dir_i` low (reverse), each falling edge of `sclk_i` loads `pb_i` into stage 32 and moves stage k to stage k-1. `pa_o` shows stage 1.
- R3: The chain keeps its contents while `sclk_i` stays at a constant level, whatever the serial inputs do.
- R4: `pb_oe_o` is high only in forward mode and `pa_oe_o` is high only in reverse mode. Exactly one of the two is high at any time.
- R5: While `latch_en_i` is high and `blank_i` is low, `par_o` equals the current chain contents.
- R6: While `latch_en_i` is low, `par_o` keeps its value while the chain goes on shifting.
- R7: While `blank_i` is high, all bits of `par_o` are 0. When `blank_i` goes low again, the unchanged latch contents reappear on `par_o`.
- R8: While `rst_ni` is low, the chain and the latch are cleared at once, with no clock edge needed. `par_o` and both serial outputs read 0, and clock edges have no effect.
- R9: When the serial output of one instance drives the serial input of a second instance, a 64-bit pattern moves correctly through both instances in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Serial clock. The chain advances on its falling edge. |
| rst_ni | input | 1 | Active-low asynchronous clear, for verification only. |
| dir_i | input | 1 | 1: port A in, port B out. 0: port B in, port A out. |
| latch_en_i | input | 1 | 1: latch transparent. 0: latch holds. |
| blank_i | input | 1 | 1: all parallel outputs forced low. |
| pa_i | input | 1 | Port A serial input value (used in forward mode). |
| pa_o | output | 1 | Port A serial output value (stage 1). |
| pa_oe_o | output | 1 | Port A drive enable (high in reverse mode). |
| pb_i | input | 1 | Port B serial input value (used in reverse mode). |
| pb_o | output | 1 | Port B serial output value (stage 32). |
| pb_oe_o | output | 1 | Port B drive enable (high in forward mode). |
| par_o | output | 32 | Parallel outputs. Bit k-1 is stage k. |

## Verification
The bench builds two instances with the default width of 32 and connects them in a cascade. Port B of the first instance feeds port A of the second, and port A of the second feeds port B of the first. This makes a 64-stage path, so the bench can follow data across the boundary between the instances in both directions. The bench checks every step against a queue model. It covers clocked steps, steps with no clock edge, held-latch phases with shifting still going on, blanking and an asynchronous clear in the middle of a run.

// File: rtl/drv_pkg.sv
package drv_pkg;
  localparam int unsigned DEF_WIDTH = 32;

  typedef enum logic {
    DIR_REV = 1'b0,
    DIR_FWD = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/drv_shift_chain.sv
module drv_shift_chain
  import drv_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             sclk_i,
  input  logic             rst_ni,
  input  shift_dir_e       dir_i,
  input  logic             a_i,
  input  logic             b_i,
  output logic [WIDTH-1:0] chain_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic [WIDTH-1:0] q, nxt;

  // per-stage source select: lower neighbour when forward, upper when reverse
  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic from_lo, from_hi;
    if (k == 0) begin : g_head
      assign from_lo = a_i;
    end else begin : g_body_lo
      assign from_lo = q[k-1];
    end
    if (k == LAST) begin : g_tail
      assign from_hi = b_i;
    end else begin : g_body_hi
      assign from_hi = q[k+1];
    end
    assign nxt[k] = (dir_i == DIR_FWD) ? from_lo : from_hi;
  end

  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign chain_o = q;
endmodule

// File: rtl/drv_hold_latch.sv
module drv_hold_latch #(
  parameter int unsigned WIDTH = drv_pkg::DEF_WIDTH
) (
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_latch begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/drv_blank_stage.sv
module drv_blank_stage #(
  parameter int unsigned WIDTH = drv_pkg::DEF_WIDTH
) (
  input  logic             blank_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  assign q_o = blank_i ? '0 : d_i;
endmodule

// File: rtl/serial_latched_driver.sv
module serial_latched_driver #(
  parameter int unsigned WIDTH = drv_pkg::DEF_WIDTH
) (
  input  logic             sclk_i,
  input  logic             rst_ni,
  input  logic             dir_i,
  input  logic             latch_en_i,
  input  logic             blank_i,
  input  logic             pa_i,
  output logic             pa_o,
  output logic             pa_oe_o,
  input  logic             pb_i,
  output logic             pb_o,
  output logic             pb_oe_o,
  output logic [WIDTH-1:0] par_o
);
  import drv_pkg::*;

  shift_dir_e       dir;
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] latch_q;

  assign dir = shift_dir_e'(dir_i);

  drv_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .sclk_i  (sclk_i),
    .rst_ni  (rst_ni),
    .dir_i   (dir),
    .a_i     (pa_i),
    .b_i     (pb_i),
    .chain_o (chain_q)
  );

  drv_hold_latch #(.WIDTH(WIDTH)) u_latch (
    .rst_ni (rst_ni),
    .en_i   (latch_en_i),
    .d_i    (chain_q),
    .q_o    (latch_q)
  );

  drv_blank_stage #(.WIDTH(WIDTH)) u_blank (
    .blank_i (blank_i),
    .d_i     (latch_q),
    .q_o     (par_o)
  );

  // serial ends: the port that is not driving is read as input
  assign pa_o    = chain_q[0];
  assign pb_o    = chain_q[WIDTH-1];
  assign pa_oe_o = (dir == DIR_REV);
  assign pb_oe_o = (dir == DIR_FWD);
endmodule

// File: rtl/drv_checker.sv
module drv_checker #(
  parameter int unsigned WIDTH = drv_pkg::DEF_WIDTH
) (
  input logic             sclk_i,
  input logic             rst_ni,
  input logic             dir_i,
  input logic             latch_en_i,
  input logic             blank_i,
  input logic             pa_i,
  input logic             pb_i,
  input logic             pa_oe_o,
  input logic             pb_oe_o,
  input logic [WIDTH-1:0] par_o,
  input logic [WIDTH-1:0] chain_q
);
  p_fwd_shift_r1: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    dir_i |=> (chain_q[0] == $past(pa_i)) &&
              (chain_q[WIDTH-1:1] == $past(chain_q[WIDTH-2:0])));

  p_rev_shift_r2: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    !dir_i |=> (chain_q[WIDTH-1] == $past(pb_i)) &&
               (chain_q[WIDTH-2:0] == $past(chain_q[WIDTH-1:1])));

  p_one_driver_r4: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    $countones({pa_oe_o, pb_oe_o}) == 1);

  p_transparent_r5: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    (latch_en_i && !blank_i) |-> (par_o == chain_q));

  p_hold_r6: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    (!latch_en_i && !blank_i && $past(!latch_en_i) && $past(!blank_i))
      |-> $stable(par_o));

  p_blank_low_r7: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    blank_i |-> (par_o == '0));
endmodule

bind serial_latched_driver drv_checker #(.WIDTH(WIDTH)) u_chk (
  .sclk_i     (sclk_i),
  .rst_ni     (rst_ni),
  .dir_i      (dir_i),
  .latch_en_i (latch_en_i),
  .blank_i    (blank_i),
  .pa_i       (pa_i),
  .pb_i       (pb_i),
  .pa_oe_o    (pa_oe_o),
  .pb_oe_o    (pb_oe_o),
  .par_o      (par_o),
  .chain_q    (chain_q)
);

// File: tb/tb_serial_latched_driver.sv
module tb_serial_latched_driver;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic sclk = 1'b0, rst_n = 1'b0, dir = 1'b1, le = 1'b1, blank = 1'b0;
  logic src_a = 1'b0, src_b = 1'b0;
  logic a0_o, a0_oe, b0_o, b0_oe, a1_o, a1_oe, b1_o, b1_oe;
  logic [W-1:0] par0, par1;

  int errors = 0, checks = 0;
  logic mq[$];
  logic [2*W-1:0] lat_m = '0;

  serial_latched_driver #(.WIDTH(W)) dut (
    .sclk_i(sclk), .rst_ni(rst_n), .dir_i(dir), .latch_en_i(le), .blank_i(blank),
    .pa_i(src_a), .pa_o(a0_o), .pa_oe_o(a0_oe),
    .pb_i(a1_o), .pb_o(b0_o), .pb_oe_o(b0_oe), .par_o(par0));

  serial_latched_driver #(.WIDTH(W)) dut_nxt (
    .sclk_i(sclk), .rst_ni(rst_n), .dir_i(dir), .latch_en_i(le), .blank_i(blank),
    .pa_i(b0_o), .pa_o(a1_o), .pa_oe_o(a1_oe),
    .pb_i(src_b), .pb_o(b1_o), .pb_oe_o(b1_oe), .par_o(par1));

  function automatic logic [2*W-1:0] model_vec();
    logic [2*W-1:0] v;
    for (int i = 0; i < 2*W; i++) v[i] = mq[i];
    return v;
  endfunction

  task automatic check(input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one period: optional falling edge, then compare mid low phase
  task automatic step(input bit clk_it, input string tag);
    sclk = clk_it;
    #(CLK_PERIOD/2);
    sclk = 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < 2*W; i++) mq[i] = 1'b0;
    end else if (clk_it) begin
      if (dir) begin
        mq.push_front(src_a);
        void'(mq.pop_back());
      end else begin
        mq.push_back(src_b);
        void'(mq.pop_front());
      end
    end
    #3;
    if (!rst_n) lat_m = '0;
    else if (le) lat_m = model_vec();
    check({tag, " par"}, {par1, par0}, blank ? '0 : lat_m);
    if (dir) begin
      check({tag, " R4 oe"}, {60'd0, a0_oe, b0_oe, a1_oe, b1_oe}, 64'b0101);
      check({tag, " R9 sout"}, {63'd0, b1_o}, {63'd0, mq[2*W-1]});
    end else begin
      check({tag, " R4 oe"}, {60'd0, a0_oe, b0_oe, a1_oe, b1_oe}, 64'b1010);
      check({tag, " R9 sout"}, {63'd0, a0_o}, {63'd0, mq[0]});
    end
    #(CLK_PERIOD/2 - 3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] pat_f, pat_r;
    pat_f = 64'hA5C3_0F1E_9B27_6D48;
    pat_r = 64'h3C96_E10B_58F2_47AD;
    for (int i = 0; i < 2*W; i++) mq.push_back(1'b0);
    src_a = 1'b1; src_b = 1'b1;
    step(1, "R8 reset");
    step(1, "R8 reset clocked");
    rst_n = 1'b1;
    for (int i = 0; i < 64; i++) begin
      src_a = pat_f[i];
      step(1, "R1 R5 R9 fwd");
    end
    for (int i = 0; i < 3; i++) begin
      src_a = ~src_a;
      step(0, "R3 no edge fwd");
    end
    le = 1'b0;
    for (int i = 0; i < 10; i++) begin
      src_a = pat_r[i];
      step(1, "R6 hold fwd");
    end
    blank = 1'b1;
    step(1, "R7 blank");
    step(0, "R7 blank");
    blank = 1'b0;
    step(0, "R7 unblank R6");
    le = 1'b1;
    step(0, "R5 reopen");
    dir = 1'b0;
    for (int i = 0; i < 64; i++) begin
      src_b = pat_r[i];
      step(1, "R2 R5 R9 rev");
    end
    for (int i = 0; i < 3; i++) begin
      src_b = ~src_b;
      step(0, "R3 no edge rev");
    end
    le = 1'b0;
    for (int i = 0; i < 6; i++) begin
      src_b = pat_f[i];
      step(1, "R6 hold rev");
    end
    le = 1'b1;
    blank = 1'b1;
    step(1, "R7 blank rev");
    blank = 1'b0;
    step(1, "R5 rev");
    rst_n = 1'b0;
    step(0, "R8 async clear");
    step(1, "R8 clocked in reset");
    rst_n = 1'b1;
    dir = 1'b1;
    for (int i = 0; i < 8; i++) begin
      src_a = pat_r[i+8];
      step(1, "R1 after reset");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule